// File: doc/BRIEF.md
# Paged nibble memory address unit

This unit produces the 12-bit address for a data memory that is four bits wide and 4,096 locations deep. The memory is seen as 16 pages of 256 locations each. The unit holds four pointers:

- two index registers, X and Y, each made of a 4-bit page field and an 8-bit in-page offset;
- an 8-bit stack pointer;
- a 4-bit register pointer.

A 2-bit select input picks the pointer that addresses the current access. The chosen address goes combinationally to the nibble RAM.

The pointers are loaded one 4-bit field at a time through a write port. Any field can be read back through a read port.

An index register's offset can be post-incremented by one or by two. The step is applied on the clock edge that ends the access. The offset wraps inside its page, so the page field never changes as a result of an increment.

The stack and register pointers can reach page 0 only. The register pointer is further limited to steps 0 to 15.

Top module: `nibble_addr_unit`

## Requirements
- R1: After reset every pointer field is zero. The address is 0x000 for every select value, and every field reads back 0.
- R2: With select 0 the address is {XP, XH, XL}, and with select 1 it is {YP, YH, YL}. The page field sits in address bits 11:8, the high offset nibble in bits 7:4 and the low offset nibble in bits 3:0.
- R3: When the increment input is high and select is 0 or 1, the current cycle still shows the pre-increment address. The chosen offset then grows by 1, or by 2 when the step input is high, on that clock edge.
- R4: An offset increment wraps modulo 256 and never changes the page field. Examples: 0xFF+1 gives 0x00, 0xFE+2 gives 0x00, and 0xFF+2 gives 0x01.
- R5: With select 2 the address is {0000, stack pointer}.
- R6: With select 3 the address is {00000000, register pointer}. This is the same RAM location that an index register set to page 0, offset 0x0R addresses.
- R7: A write stores the 4-bit data into the field named by the field code on the next clock edge. That field is then readable through the read port.
  - Codes 0, 1 and 2 are XP, XH and XL.
  - Codes 3, 4 and 5 are YP, YH and YL.
  - Codes 6 and 7 are the stack pointer's high and low nibbles.
  - Code 8 is the register pointer.
- R8: Field codes 9 to 15 change no pointer on a write, and read back as 0.
- R9: The increment has no effect while select is 2 or 3.
- R10: A write to any field of the index register being incremented takes precedence, and the increment is dropped for that cycle. A write to a field of the other index register does not block the increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 2 | Address source: 0 X, 1 Y, 2 stack pointer, 3 register pointer |
| inc_en | input | 1 | Post-increment the selected index offset at this edge |
| inc_two | input | 1 | Increment step: 0 adds 1, 1 adds 2 |
| wr_en | input | 1 | Field write strobe |
| wr_field | input | 4 | Field code for the write |
| wr_data | input | 4 | Nibble to write |
| rd_field | input | 4 | Field code for the read port |
| rd_data | output | 4 | Contents of the field named by rd_field |
| addr | output | 12 | Data memory address |

## Verification
The bench drives offsets to 0xFF and 0xFE and increments them by 1 and by 2. A design that carried into the page would move the address to the next page instead of wrapping within the same one.

It checks the address both during an increment cycle and after it. A design that applied the increment too early would show the wrong address for the current access.

It increments while the stack or register pointer is selected, and it writes the unused field codes. A design that leaked either action would corrupt a pointer that the bench then reads back.

It also writes and increments the same index register in one cycle. An incorrect design would either mix the two results or let the increment win. Finally, it writes the RAM through X and reads it back through the register pointer, which exposes a register pointer that is not confined to the low 16 locations of page 0.

// File: rtl/nibble_addr_unit.sv
module nibble_addr_unit #(
  parameter int PAGE_W  = 4,
  parameter int NIB_W   = 4,
  parameter int FIELD_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0]                  sel,
  input  logic                        inc_en,
  input  logic                        inc_two,
  input  logic                        wr_en,
  input  logic [FIELD_W-1:0]          wr_field,
  input  logic [NIB_W-1:0]            wr_data,
  input  logic [FIELD_W-1:0]          rd_field,
  output logic [NIB_W-1:0]            rd_data,
  output logic [PAGE_W+2*NIB_W-1:0]   addr
);
  localparam int OFS_W  = 2 * NIB_W;
  localparam int ADDR_W = PAGE_W + OFS_W;

  logic [PAGE_W-1:0] xp, yp;
  logic [OFS_W-1:0]  xo, yo, sp;
  logic [NIB_W-1:0]  rp;

  wire [OFS_W-1:0] step = inc_two ? OFS_W'(2) : OFS_W'(1);
  wire wr_x  = wr_en && (wr_field <= FIELD_W'(2));
  wire wr_y  = wr_en && (wr_field >= FIELD_W'(3)) && (wr_field <= FIELD_W'(5));
  wire inc_x = inc_en && (sel == 2'd0) && !wr_x;
  wire inc_y = inc_en && (sel == 2'd1) && !wr_y;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xp <= '0; yp <= '0; xo <= '0; yo <= '0; sp <= '0; rp <= '0;
    end else begin
      if (wr_en) begin
        case (wr_field)
          FIELD_W'(0): xp <= PAGE_W'(wr_data);
          FIELD_W'(1): xo[OFS_W-1:NIB_W] <= wr_data;
          FIELD_W'(2): xo[NIB_W-1:0] <= wr_data;
          FIELD_W'(3): yp <= PAGE_W'(wr_data);
          FIELD_W'(4): yo[OFS_W-1:NIB_W] <= wr_data;
          FIELD_W'(5): yo[NIB_W-1:0] <= wr_data;
          FIELD_W'(6): sp[OFS_W-1:NIB_W] <= wr_data;
          FIELD_W'(7): sp[NIB_W-1:0] <= wr_data;
          FIELD_W'(8): rp <= wr_data;
          default: ;
        endcase
      end
      if (inc_x) xo <= xo + step;
      if (inc_y) yo <= yo + step;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_field)
      FIELD_W'(0): rd_data = NIB_W'(xp);
      FIELD_W'(1): rd_data = xo[OFS_W-1:NIB_W];
      FIELD_W'(2): rd_data = xo[NIB_W-1:0];
      FIELD_W'(3): rd_data = NIB_W'(yp);
      FIELD_W'(4): rd_data = yo[OFS_W-1:NIB_W];
      FIELD_W'(5): rd_data = yo[NIB_W-1:0];
      FIELD_W'(6): rd_data = sp[OFS_W-1:NIB_W];
      FIELD_W'(7): rd_data = sp[NIB_W-1:0];
      FIELD_W'(8): rd_data = rp;
      default:     rd_data = '0;
    endcase
  end

  always_comb begin
    addr = '0;
    case (sel)
      2'd0: addr = {xp, xo};
      2'd1: addr = {yp, yo};
      2'd2: addr = ADDR_W'(sp);
      2'd3: addr = ADDR_W'(rp);
      default: addr = '0;
    endcase
  end

  // R4: an increment never disturbs the page field
  p_page_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && sel == 2'd0 && !wr_en) |=> xp == $past(xp));

  // R3: offset advances by the requested step
  p_inc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && sel == 2'd1 && !wr_en) |=> yo == $past(yo) + $past(step));

  // R9: no increment while stack or register pointer is selected
  p_no_inc_other_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && sel[1] && !wr_en) |=> ($stable(xo) && $stable(yo)));

  // R10: a write to the incremented register wins
  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && sel == 2'd0 && wr_en && wr_field == FIELD_W'(2))
    |=> xo[NIB_W-1:0] == $past(wr_data));

  // R7: register pointer load lands on the next edge
  p_rp_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_field == FIELD_W'(8)) |=> rp == $past(wr_data));
endmodule

// File: tb/nibble_addr_unit_test.sv
module nibble_addr_unit_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] sel = 2'd0;
  logic inc_en = 1'b0, inc_two = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_field = 4'd0, wr_data = 4'd0, rd_field = 4'd0;
  logic [3:0] rd_data;
  logic [11:0] addr;
  logic ram_we = 1'b0;
  logic [3:0] ram_wd = 4'd0;
  logic [3:0] mem [0:4095];
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (ram_we) mem[addr] <= ram_wd;

  nibble_addr_unit uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .inc_en(inc_en), .inc_two(inc_two),
    .wr_en(wr_en), .wr_field(wr_field), .wr_data(wr_data),
    .rd_field(rd_field), .rd_data(rd_data), .addr(addr)
  );

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [3:0] f, input logic [3:0] d);
    @(negedge clk); wr_en = 1'b1; wr_field = f; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic see(input logic [1:0] s, input logic [11:0] exp, input string tag);
    sel = s; #1 chk(tag, addr, exp);
  endtask

  task automatic peek(input logic [3:0] f, input logic [3:0] exp, input string tag);
    rd_field = f; #1 chk(tag, {8'h0, rd_data}, {8'h0, exp});
  endtask

  task automatic bump(input logic [1:0] s, input logic two, input logic [11:0] pre,
                      input logic [11:0] post, input string tag);
    @(negedge clk); sel = s; inc_en = 1'b1; inc_two = two;
    #1 chk({tag, " pre"}, addr, pre);
    @(negedge clk); inc_en = 1'b0;
    #1 chk({tag, " post"}, addr, post);
  endtask

  task automatic t_reset;
    for (int s = 0; s < 4; s++) see(2'(s), 12'h000, "R1 reset addr");
    for (int f = 0; f < 9; f++) peek(4'(f), 4'h0, "R1 reset field");
  endtask

  task automatic t_compose;
    put(4'd0, 4'h3); put(4'd1, 4'hA); put(4'd2, 4'h5);
    put(4'd3, 4'hC); put(4'd4, 4'h1); put(4'd5, 4'hE);
    see(2'd0, 12'h3A5, "R2 X address");
    see(2'd1, 12'hC1E, "R2 Y address");
    peek(4'd1, 4'hA, "R7 XH readback");
    peek(4'd3, 4'hC, "R7 YP readback");
  endtask

  task automatic t_inc;
    bump(2'd0, 1'b0, 12'h3A5, 12'h3A6, "R3 X +1");
    bump(2'd0, 1'b1, 12'h3A6, 12'h3A8, "R3 X +2");
  endtask

  task automatic t_wrap;
    put(4'd1, 4'hF); put(4'd2, 4'hF);
    bump(2'd0, 1'b0, 12'h3FF, 12'h300, "R4 X FF+1");
    put(4'd4, 4'hF); put(4'd5, 4'hE);
    bump(2'd1, 1'b1, 12'hCFE, 12'hC00, "R4 Y FE+2");
    put(4'd4, 4'hF); put(4'd5, 4'hF);
    bump(2'd1, 1'b1, 12'hCFF, 12'hC01, "R4 Y FF+2");
    peek(4'd3, 4'hC, "R4 Y page kept");
  endtask

  task automatic t_sp_rp;
    put(4'd6, 4'h9); put(4'd7, 4'h7);
    see(2'd2, 12'h097, "R5 SP address");
    bump(2'd2, 1'b0, 12'h097, 12'h097, "R9 SP no inc");
    put(4'd8, 4'hB);
    see(2'd3, 12'h00B, "R6 RP address");
    bump(2'd3, 1'b1, 12'h00B, 12'h00B, "R9 RP no inc");
    see(2'd0, 12'h300, "R9 X untouched");
    see(2'd1, 12'hC01, "R9 Y untouched");
  endtask

  task automatic t_unused;
    for (int f = 9; f < 16; f++) put(4'(f), 4'hF);
    see(2'd0, 12'h300, "R8 X after unused");
    see(2'd1, 12'hC01, "R8 Y after unused");
    see(2'd2, 12'h097, "R8 SP after unused");
    see(2'd3, 12'h00B, "R8 RP after unused");
    peek(4'd12, 4'h0, "R8 unused reads 0");
  endtask

  task automatic t_conflict;
    @(negedge clk); sel = 2'd0; inc_en = 1'b1; inc_two = 1'b0;
    wr_en = 1'b1; wr_field = 4'd2; wr_data = 4'h4;
    @(negedge clk); inc_en = 1'b0; wr_en = 1'b0;
    see(2'd0, 12'h304, "R10 write beats inc");
    @(negedge clk); sel = 2'd0; inc_en = 1'b1; inc_two = 1'b1;
    wr_en = 1'b1; wr_field = 4'd3; wr_data = 4'h2;
    @(negedge clk); inc_en = 1'b0; wr_en = 1'b0;
    see(2'd0, 12'h306, "R10 other-reg write keeps inc");
    see(2'd1, 12'h201, "R10 Y page written");
  endtask

  task automatic t_ram;
    put(4'd0, 4'h0); put(4'd1, 4'h0); put(4'd2, 4'h5);
    @(negedge clk); sel = 2'd0; ram_we = 1'b1; ram_wd = 4'h6;
    @(negedge clk); ram_we = 1'b0;
    put(4'd8, 4'h5);
    sel = 2'd3; #1 chk("R6 RP hits page0 step5", {8'h0, mem[addr]}, 12'h006);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1 t_reset();
    rst_n = 1'b1;
    t_compose();
    t_inc();
    t_wrap();
    t_sp_rp();
    t_unused();
    t_conflict();
    t_ram();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule